// File: doc/BRIEF.md
# Template-Selected ACL Key Matcher

This block classifies a packet against a small bank of ternary rules. The parsed header of the packet arrives in one cycle. The block then builds a lookup key of twelve 16-bit slots and one fixed word for every rule. The contents of the key slots are not fixed. Each rule carries a 2-bit template ID. That ID picks one of three 3-bit template numbers held in the selector word of the rule's block. The chosen number then names one of five fixed templates, and the template decides which header slice lands in each slot.

Every valid rule compares its own key against its stored data under its stored care-mask. A mask bit of 0 means the bit is not compared. The lowest-numbered rule that hits is reported one clock later, together with a result strobe. Rules and selectors are loaded through a single word-write port. Each rule holds fifteen 32-bit words: six slot-data words, a fixed-data word, six slot-mask words, a fixed-mask word and a control word.

Top module: `acl_tmpl_matcher`

## Requirements
- R1: After reset no result is reported (res_valid=0, res_hit=0, res_idx=0), every rule is invalid, even blocks hold template numbers {0,1,2} and odd blocks hold {0,3,4}, for template IDs {0,1,2}.
- R2: Key slot i is compared with bits [15:0] of rule word 5-i/2 when i is even and with bits [31:16] of that word when i is odd. Its mask comes from the same half of word 12-i/2.
- R3: A rule with template ID t in [1:0] of word 6 uses template number sel[3t+2:3t] of its own block's selector.
- R4: Templates by slot 0..11: T0 = pmask lo, pmask hi, outer tag, SA0, SA1, SA2, DA0, DA1, DA2, EtherType, inner tag, range. T1 = SIP0, SIP1, DIP0, DIP1, TOS/proto, L4 src, L4 dst, ICMP/IGMP, inner tag, range, pmask lo, pmask hi. T2 = DA0, DA1, DA2, inner tag, EtherType, TOS/proto, L4 dst, L4 src, SIP0, SIP1, DIP0, DIP1. T3 = DIP0..DIP7, L4 dst, L4 src, ICMP/IGMP, TOS/proto. T4 = SIP0..SIP7, inner tag, range, pmask lo, pmask hi.
- R5: MAC part k (SA/DA k) carries address bits [16k+15:16k], so the lowest-order byte pair is in part 0. IP part k carries address bits [16k+15:16k].
- R6: When hdr_is_v6=0, IP address parts 2..7 of both addresses read as zero, whatever the upper input bits are.
- R7: A rule hits only if every slot and the fixed word satisfy ((key ^ data) & mask) == 0. The fixed key word is {8'b0, hdr_fix, template ID}, so hdr_fix[j] meets word-6/word-13 bit j+2 (for example, source port number hdr_fix[19:14] meets bits [21:16]).
- R8: A rule can hit only when bit 31 of its control word (word 14) is set. Bits 30..28 have no effect on the hit.
- R9: When several rules hit, res_idx is the lowest index among them.
- R10: res_valid equals pkt_valid one clock earlier. res_hit and res_idx report the packet presented in that earlier cycle, and res_idx is 0 when there is no hit.
- R11: A rule with template ID 3, or whose selected template number is 5..7, never hits.
- R12: A write with wr_sel=1 replaces the selector of block wr_addr[BLK_W-1:0] with wr_data[8:0]. A write with wr_sel=0 stores wr_data in word wr_addr[3:0] (0..14) of rule wr_addr[ADDR_W-1:4]. Both take effect for packets presented after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | 1: selector write, 0: rule word write |
| wr_addr | input | ADDR_W (6) | {rule index, word index} or block index |
| wr_data | input | 32 | Write data |
| pkt_valid | input | 1 | Header bus carries a packet this cycle |
| hdr_pmask | input | 32 | Source port mask |
| hdr_dmac | input | 48 | Destination MAC |
| hdr_smac | input | 48 | Source MAC |
| hdr_etype | input | 16 | EtherType |
| hdr_ovlan | input | 16 | Outer VLAN tag |
| hdr_ivlan | input | 16 | Inner VLAN tag |
| hdr_range | input | 16 | Range-check result vector |
| hdr_tosp | input | 16 | TOS/traffic class and protocol/next header |
| hdr_l4_src | input | 16 | L4 source port |
| hdr_l4_dst | input | 16 | L4 destination port |
| hdr_icmp | input | 16 | ICMP/IGMP type and code |
| hdr_sip | input | 128 | Source IP (IPv4 in [31:0]) |
| hdr_dip | input | 128 | Destination IP (IPv4 in [31:0]) |
| hdr_is_v6 | input | 1 | Packet is IPv6 |
| hdr_fix | input | 22 | Fixed match bits, placed at key fixed-word bits [23:2] |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Some valid rule hit |
| res_idx | output | RIDX_W (2) | Lowest hitting rule index |

## Verification
A corrupted rule word, selector or template entry does not disturb the strobe. It shows up as a wrong res_hit or res_idx in the cycle right after the first packet that touches the damaged slot. That packet can come long after the write that caused the damage. For this reason the bench keeps its own image of every rule and selector, fed only from the write port. It predicts every result cycle, so a divergence is reported in the first cycle it becomes visible. Directed packets aim at single slots, halves, byte orders and selector fields, so that a swapped half or a wrong shift cannot stay hidden behind a wildcard mask.

// File: rtl/acl_match_pkg.sv
// Shared constants, header type and the fixed template table of the key matcher.
// Assumes templates are fixed at build time; user templates are not modelled.
package acl_match_pkg;
    localparam int SLOTS      = 12;
    localparam int SLOT_W     = 16;
    localparam int NUM_TMPL   = 5;
    localparam int RULE_WORDS = 15;
    localparam int W_FIX      = 6;
    localparam int W_FIXM     = 13;
    localparam int W_CTRL     = 14;
    localparam int FIX_HDR_W  = 22;
    localparam int SEL_W      = 9;

    // Header slices that a template may place in a slot; address parts last.
    typedef enum logic [4:0] {
        FLD_PM_LO, FLD_PM_HI, FLD_RANGE, FLD_DA0, FLD_DA1, FLD_DA2,
        FLD_SA0, FLD_SA1, FLD_SA2, FLD_ETYPE, FLD_OVLAN, FLD_IVLAN,
        FLD_TOSP, FLD_L4S, FLD_L4D, FLD_ICMP,
        FLD_SRC0, FLD_SRC1, FLD_SRC2, FLD_SRC3, FLD_SRC4, FLD_SRC5, FLD_SRC6, FLD_SRC7,
        FLD_DST0, FLD_DST1, FLD_DST2, FLD_DST3, FLD_DST4, FLD_DST5, FLD_DST6, FLD_DST7
    } fld_e;

    typedef struct packed {
        logic [31:0]          pmask;
        logic [47:0]          dmac;
        logic [47:0]          smac;
        logic [15:0]          etype;
        logic [15:0]          ovlan;
        logic [15:0]          ivlan;
        logic [15:0]          rng;
        logic [15:0]          tosp;
        logic [15:0]          l4s;
        logic [15:0]          l4d;
        logic [15:0]          icmp;
        logic [127:0]         sip;
        logic [127:0]         dip;
        logic                 is_v6;
        logic [FIX_HDR_W-1:0] fix;
    } hdr_t;

    localparam fld_e TMPL [NUM_TMPL][SLOTS] = '{
        '{FLD_PM_LO, FLD_PM_HI, FLD_OVLAN, FLD_SA0, FLD_SA1, FLD_SA2,
          FLD_DA0, FLD_DA1, FLD_DA2, FLD_ETYPE, FLD_IVLAN, FLD_RANGE},
        '{FLD_SRC0, FLD_SRC1, FLD_DST0, FLD_DST1, FLD_TOSP, FLD_L4S,
          FLD_L4D, FLD_ICMP, FLD_IVLAN, FLD_RANGE, FLD_PM_LO, FLD_PM_HI},
        '{FLD_DA0, FLD_DA1, FLD_DA2, FLD_IVLAN, FLD_ETYPE, FLD_TOSP,
          FLD_L4D, FLD_L4S, FLD_SRC0, FLD_SRC1, FLD_DST0, FLD_DST1},
        '{FLD_DST0, FLD_DST1, FLD_DST2, FLD_DST3, FLD_DST4, FLD_DST5,
          FLD_DST6, FLD_DST7, FLD_L4D, FLD_L4S, FLD_ICMP, FLD_TOSP},
        '{FLD_SRC0, FLD_SRC1, FLD_SRC2, FLD_SRC3, FLD_SRC4, FLD_SRC5,
          FLD_SRC6, FLD_SRC7, FLD_IVLAN, FLD_RANGE, FLD_PM_LO, FLD_PM_HI}
    };

    // Returns the 16-bit header slice named by a field identifier.
    function automatic logic [SLOT_W-1:0] field_val(fld_e f, hdr_t h);
        logic [SLOT_W-1:0] v;
        int k;
        k = int'(f) - int'(FLD_SRC0);
        case (f)
            FLD_PM_LO: v = h.pmask[15:0];
            FLD_PM_HI: v = h.pmask[31:16];
            FLD_RANGE: v = h.rng;
            FLD_DA0:   v = h.dmac[15:0];
            FLD_DA1:   v = h.dmac[31:16];
            FLD_DA2:   v = h.dmac[47:32];
            FLD_SA0:   v = h.smac[15:0];
            FLD_SA1:   v = h.smac[31:16];
            FLD_SA2:   v = h.smac[47:32];
            FLD_ETYPE: v = h.etype;
            FLD_OVLAN: v = h.ovlan;
            FLD_IVLAN: v = h.ivlan;
            FLD_TOSP:  v = h.tosp;
            FLD_L4S:   v = h.l4s;
            FLD_L4D:   v = h.l4d;
            FLD_ICMP:  v = h.icmp;
            default: begin
                if (k >= 8) v = h.dip[16*(k-8) +: 16];
                else        v = h.sip[16*k +: 16];
            end
        endcase
        return v;
    endfunction
endpackage

// File: rtl/acl_key_builder.sv
// Builds the twelve key slots for every fixed template in parallel.
// Assumes the header is already parsed; IPv4 addresses sit in bits [31:0].
module acl_key_builder
    import acl_match_pkg::*;
(
    input  hdr_t                                          hdr_i,
    output logic [NUM_TMPL-1:0][SLOTS-1:0][SLOT_W-1:0]    key_o
);
    hdr_t h_eff;

    // Clears the upper address parts of non-IPv6 packets.
    always_comb begin
        h_eff = hdr_i;
        if (!hdr_i.is_v6) begin
            h_eff.sip[127:32] = '0;
            h_eff.dip[127:32] = '0;
        end
    end

    for (genvar t = 0; t < NUM_TMPL; t++) begin : g_tmpl
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            assign key_o[t][i] = field_val(TMPL[t][i], h_eff);
        end
    end
endmodule

// File: rtl/acl_rule_store.sv
// Holds the rule words and the per-block template selectors behind one write port.
// Assumes N_BLOCKS and RULES_PER_BLOCK are powers of two and N_BLOCKS >= 2.
module acl_rule_store
    import acl_match_pkg::*;
#(
    parameter int N_BLOCKS        = 2,
    parameter int RULES_PER_BLOCK = 2,
    localparam int N_RULES = N_BLOCKS * RULES_PER_BLOCK,
    localparam int RIDX_W  = $clog2(N_RULES),
    localparam int BLK_W   = $clog2(N_BLOCKS),
    localparam int ADDR_W  = RIDX_W + 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic                                     wr_sel,
    input  logic [ADDR_W-1:0]                        wr_addr,
    input  logic [31:0]                              wr_data,
    output logic [N_RULES-1:0][RULE_WORDS-1:0][31:0] rule_o,
    output logic [N_BLOCKS-1:0][SEL_W-1:0]           sel_o
);
    localparam logic [SEL_W-1:0] DEF_EVEN = {3'd2, 3'd1, 3'd0};
    localparam logic [SEL_W-1:0] DEF_ODD  = {3'd4, 3'd3, 3'd0};

    logic [RIDX_W-1:0] ridx;
    logic [3:0]        widx;
    assign ridx = wr_addr[ADDR_W-1:4];
    assign widx = wr_addr[3:0];

    // Stores one rule word per write; word index 15 is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_o <= '0;
        end else if (wr_en && !wr_sel && widx < 4'(RULE_WORDS)) begin
            rule_o[ridx][widx] <= wr_data;
        end
    end

    for (genvar b = 0; b < N_BLOCKS; b++) begin : g_sel
        // Loads the block selector, starting from the parity default.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_o[b] <= (b % 2 == 1) ? DEF_ODD : DEF_EVEN;
            end else if (wr_en && wr_sel && wr_addr[BLK_W-1:0] == BLK_W'(b)) begin
                sel_o[b] <= wr_data[SEL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/acl_rule_cmp.sv
// Ternary compare of one rule against the key of its selected template.
// Assumes the selector of the rule's own block is supplied.
module acl_rule_cmp
    import acl_match_pkg::*;
(
    input  logic [NUM_TMPL-1:0][SLOTS-1:0][SLOT_W-1:0] key_i,
    input  logic [RULE_WORDS-1:0][31:0]                 rule_i,
    input  logic [SEL_W-1:0]                            sel_i,
    input  logic [FIX_HDR_W-1:0]                        hdr_fix_i,
    output logic                                        hit_o
);
    logic [1:0]  tid;
    logic [2:0]  tnum;
    logic        tmpl_ok;
    logic [2:0]  tpick;
    logic [31:0] key_fix;
    logic        miss;
    logic        unused_ctrl;

    assign tid         = rule_i[W_FIX][1:0];
    assign unused_ctrl = ^rule_i[W_CTRL][30:0];

    // Picks the template number named by the rule's template ID.
    always_comb begin
        case (tid)
            2'd0:    tnum = sel_i[2:0];
            2'd1:    tnum = sel_i[5:3];
            2'd2:    tnum = sel_i[8:6];
            default: tnum = 3'd7;
        endcase
        tmpl_ok = (tnum < 3'(NUM_TMPL));
        tpick   = tmpl_ok ? tnum : 3'd0;
    end

    // Accumulates masked mismatches over the fixed word and all slots.
    always_comb begin
        key_fix = {8'b0, hdr_fix_i, tid};
        miss    = |((key_fix ^ rule_i[W_FIX]) & rule_i[W_FIXM]);
        for (int i = 0; i < SLOTS; i++) begin
            if (|((key_i[tpick][i] ^ rule_i[5 - i/2][16*(i%2) +: 16])
                  & rule_i[12 - i/2][16*(i%2) +: 16]))
                miss = 1'b1;
        end
    end

    assign hit_o = rule_i[W_CTRL][31] && tmpl_ok && !miss;
endmodule

// File: rtl/acl_first_hit.sv
// Priority pick of the lowest-indexed set bit of a hit vector.
// Assumes N >= 2.
module acl_first_hit #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Scans from the top so the lowest set index is written last.
    always_comb begin
        found_o = |hits_i;
        idx_o   = '0;
        for (int r = N - 1; r >= 0; r--) begin
            if (hits_i[r]) idx_o = IW'(r);
        end
    end
endmodule

// File: rtl/acl_tmpl_matcher.sv
// Top: template-selected key build, per-rule ternary compare, registered result.
// Assumes one packet per cycle at most; the result follows one clock later.
module acl_tmpl_matcher
    import acl_match_pkg::*;
#(
    parameter int N_BLOCKS        = 2,
    parameter int RULES_PER_BLOCK = 2,
    localparam int N_RULES = N_BLOCKS * RULES_PER_BLOCK,
    localparam int RIDX_W  = $clog2(N_RULES),
    localparam int ADDR_W  = RIDX_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              pkt_valid,
    input  logic [31:0]       hdr_pmask,
    input  logic [47:0]       hdr_dmac,
    input  logic [47:0]       hdr_smac,
    input  logic [15:0]       hdr_etype,
    input  logic [15:0]       hdr_ovlan,
    input  logic [15:0]       hdr_ivlan,
    input  logic [15:0]       hdr_range,
    input  logic [15:0]       hdr_tosp,
    input  logic [15:0]       hdr_l4_src,
    input  logic [15:0]       hdr_l4_dst,
    input  logic [15:0]       hdr_icmp,
    input  logic [127:0]      hdr_sip,
    input  logic [127:0]      hdr_dip,
    input  logic              hdr_is_v6,
    input  logic [21:0]       hdr_fix,
    output logic              res_valid,
    output logic              res_hit,
    output logic [RIDX_W-1:0] res_idx
);
    hdr_t                                       hdr;
    logic [NUM_TMPL-1:0][SLOTS-1:0][SLOT_W-1:0] keys;
    logic [N_RULES-1:0][RULE_WORDS-1:0][31:0]   rules;
    logic [N_BLOCKS-1:0][SEL_W-1:0]             sels;
    logic [N_RULES-1:0]                         rule_hit;
    logic                                       any_hit;
    logic [RIDX_W-1:0]                          win_idx;

    assign hdr = '{pmask: hdr_pmask, dmac: hdr_dmac, smac: hdr_smac,
                   etype: hdr_etype, ovlan: hdr_ovlan, ivlan: hdr_ivlan,
                   rng: hdr_range, tosp: hdr_tosp, l4s: hdr_l4_src,
                   l4d: hdr_l4_dst, icmp: hdr_icmp, sip: hdr_sip,
                   dip: hdr_dip, is_v6: hdr_is_v6, fix: hdr_fix};

    acl_key_builder key_i (.hdr_i(hdr), .key_o(keys));

    acl_rule_store #(.N_BLOCKS(N_BLOCKS), .RULES_PER_BLOCK(RULES_PER_BLOCK)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .rule_o(rules), .sel_o(sels)
    );

    for (genvar r = 0; r < N_RULES; r++) begin : g_rule
        acl_rule_cmp cmp_i (
            .key_i(keys), .rule_i(rules[r]), .sel_i(sels[r / RULES_PER_BLOCK]),
            .hdr_fix_i(hdr_fix), .hit_o(rule_hit[r])
        );
    end

    acl_first_hit #(.N(N_RULES)) pick_i (.hits_i(rule_hit), .found_o(any_hit), .idx_o(win_idx));

    // Registers the result of the packet presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
        end else begin
            res_valid <= pkt_valid;
            res_hit   <= pkt_valid && any_hit;
            res_idx   <= (pkt_valid && any_hit) ? win_idx : '0;
        end
    end
endmodule

// File: rtl/acl_tmpl_matcher_chk.sv
// Checker for the result register against the per-rule compare outputs.
// Assumes it is bound into acl_tmpl_matcher and sees its rule_hit vector.
module acl_tmpl_matcher_chk #(
    parameter int N_RULES = 4,
    parameter int RIDX_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic [N_RULES-1:0] rule_hit,
    input logic               res_valid,
    input logic               res_hit,
    input logic [RIDX_W-1:0]  res_idx
);
    logic [N_RULES-1:0] prev_hits;
    logic [N_RULES-1:0] below;

    // Keeps the compare outputs of the packet behind the current result.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_hits <= '0;
        else        prev_hits <= pkt_valid ? rule_hit : '0;
    end

    assign below = (N_RULES'(1) << res_idx) - N_RULES'(1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid && !res_hit && res_idx == '0);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> res_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !res_valid);
    // R10
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_idx == '0);
    // R9
    winner_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> prev_hits[res_idx]);
    // R9
    winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (prev_hits & below) == '0);
    // R9
    miss_means_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_hit |-> prev_hits == '0);
endmodule

bind acl_tmpl_matcher acl_tmpl_matcher_chk #(.N_RULES(N_RULES), .RIDX_W(RIDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .rule_hit(rule_hit),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
);

// File: tb/acl_tmpl_matcher_tb_top.sv
module acl_tmpl_matcher_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, wr_sel = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         pkt_valid = 1'b0;
    logic [31:0]  hdr_pmask;
    logic [47:0]  hdr_dmac, hdr_smac;
    logic [15:0]  hdr_etype, hdr_ovlan, hdr_ivlan, hdr_range, hdr_tosp;
    logic [15:0]  hdr_l4_src, hdr_l4_dst, hdr_icmp;
    logic [127:0] hdr_sip, hdr_dip;
    logic         hdr_is_v6;
    logic [21:0]  hdr_fix;
    logic         res_valid, res_hit;
    logic [1:0]   res_idx;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // bench-side image of the configuration, fed from the write port only
    logic [31:0] mw [4][15];
    logic [8:0]  ms [2];
    logic        exp_valid = 1'b0, exp_hit = 1'b0;
    logic [1:0]  exp_idx = '0;
    logic [31:0] nw [15];

    always #(CLK_PERIOD/2) clk = ~clk;

    acl_tmpl_matcher dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .pkt_valid(pkt_valid), .hdr_pmask(hdr_pmask),
        .hdr_dmac(hdr_dmac), .hdr_smac(hdr_smac), .hdr_etype(hdr_etype),
        .hdr_ovlan(hdr_ovlan), .hdr_ivlan(hdr_ivlan), .hdr_range(hdr_range),
        .hdr_tosp(hdr_tosp), .hdr_l4_src(hdr_l4_src), .hdr_l4_dst(hdr_l4_dst),
        .hdr_icmp(hdr_icmp), .hdr_sip(hdr_sip), .hdr_dip(hdr_dip),
        .hdr_is_v6(hdr_is_v6), .hdr_fix(hdr_fix), .res_valid(res_valid),
        .res_hit(res_hit), .res_idx(res_idx)
    );

    task automatic chk(string req, bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // header slice for template t, slot i, as the requirements list them (R4, R5, R6)
    function automatic logic [15:0] fv(int t, int i);
        logic [127:0] s, d;
        s = hdr_is_v6 ? hdr_sip : {96'b0, hdr_sip[31:0]};
        d = hdr_is_v6 ? hdr_dip : {96'b0, hdr_dip[31:0]};
        case (t)
            0: case (i)
                0: return hdr_pmask[15:0];   1: return hdr_pmask[31:16];
                2: return hdr_ovlan;         3: return hdr_smac[15:0];
                4: return hdr_smac[31:16];   5: return hdr_smac[47:32];
                6: return hdr_dmac[15:0];    7: return hdr_dmac[31:16];
                8: return hdr_dmac[47:32];   9: return hdr_etype;
                10: return hdr_ivlan;        default: return hdr_range;
            endcase
            1: case (i)
                0: return s[15:0];  1: return s[31:16]; 2: return d[15:0]; 3: return d[31:16];
                4: return hdr_tosp; 5: return hdr_l4_src; 6: return hdr_l4_dst; 7: return hdr_icmp;
                8: return hdr_ivlan; 9: return hdr_range; 10: return hdr_pmask[15:0];
                default: return hdr_pmask[31:16];
            endcase
            2: case (i)
                0: return hdr_dmac[15:0]; 1: return hdr_dmac[31:16]; 2: return hdr_dmac[47:32];
                3: return hdr_ivlan; 4: return hdr_etype; 5: return hdr_tosp;
                6: return hdr_l4_dst; 7: return hdr_l4_src; 8: return s[15:0];
                9: return s[31:16]; 10: return d[15:0]; default: return d[31:16];
            endcase
            3: begin
                if (i < 8) return d[16*i +: 16];
                case (i) 8: return hdr_l4_dst; 9: return hdr_l4_src; 10: return hdr_icmp;
                    default: return hdr_tosp; endcase
            end
            default: begin
                if (i < 8) return s[16*i +: 16];
                case (i) 8: return hdr_ivlan; 9: return hdr_range; 10: return hdr_pmask[15:0];
                    default: return hdr_pmask[31:16]; endcase
            end
        endcase
    endfunction

    // expected lowest hitting rule for the current header, -1 for none
    function automatic int model_match();
        for (int r = 0; r < 4; r++) begin
            int tid, tn;
            bit ok;
            if (!mw[r][14][31]) continue;
            tid = int'(mw[r][6][1:0]);
            if (tid == 3) continue;
            tn = int'(ms[r/2][3*tid +: 3]);
            if (tn > 4) continue;
            ok = ((({8'b0, hdr_fix, 2'(tid)}) ^ mw[r][6]) & mw[r][13]) == 0;
            for (int i = 0; i < 12; i++) begin
                logic [15:0] dd, mm;
                dd = (i % 2 == 1) ? mw[r][5 - i/2][31:16] : mw[r][5 - i/2][15:0];
                mm = (i % 2 == 1) ? mw[r][12 - i/2][31:16] : mw[r][12 - i/2][15:0];
                if (((fv(tn, i) ^ dd) & mm) != 0) ok = 0;
            end
            if (ok) return r;
        end
        return -1;
    endfunction

    // every-cycle comparison against the model, then model update
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 4; r++) for (int w = 0; w < 15; w++) mw[r][w] = '0;
            ms[0] = {3'd2, 3'd1, 3'd0};
            ms[1] = {3'd4, 3'd3, 3'd0};
            exp_valid = 0; exp_hit = 0; exp_idx = 0;
        end else begin
            int m;
            chk({cur_req, " per-cycle"},
                res_valid === exp_valid && res_hit === exp_hit && res_idx === exp_idx,
                "{valid,hit,idx}", int'({res_valid, res_hit, res_idx}),
                int'({exp_valid, exp_hit, exp_idx}));
            m = model_match();
            exp_valid = pkt_valid;
            exp_hit   = pkt_valid && m >= 0;
            exp_idx   = (pkt_valid && m >= 0) ? 2'(m) : 2'd0;
            if (wr_en) begin
                if (wr_sel) ms[wr_addr[0]] = wr_data[8:0];
                else if (wr_addr[3:0] != 4'd15) mw[wr_addr[5:4]][wr_addr[3:0]] = wr_data;
            end
        end
    end

    task automatic wr_word(bit sel, logic [5:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = sel; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0; wr_sel = 0;
    endtask

    task automatic clr_rule();
        for (int w = 0; w < 15; w++) nw[w] = '0;
    endtask

    task automatic put_slot(int i, logic [15:0] d, logic [15:0] m);
        if (i % 2 == 1) begin
            nw[5 - i/2][31:16] = d; nw[12 - i/2][31:16] = m;
        end else begin
            nw[5 - i/2][15:0] = d;  nw[12 - i/2][15:0] = m;
        end
    endtask

    task automatic put_fix(logic [1:0] tid, logic [21:0] v, logic [21:0] m);
        nw[6]  = {8'b0, v, tid};
        nw[13] = {8'b0, m, 2'b11};
    endtask

    task automatic commit(int r, logic [31:0] ctrl);
        nw[14] = ctrl;
        for (int w = 0; w < 15; w++) wr_word(0, {2'(r), 4'(w)}, nw[w]);
    endtask

    task automatic clear_hdr();
        hdr_pmask = 0; hdr_dmac = 0; hdr_smac = 0; hdr_etype = 0; hdr_ovlan = 0;
        hdr_ivlan = 0; hdr_range = 0; hdr_tosp = 0; hdr_l4_src = 0; hdr_l4_dst = 0;
        hdr_icmp = 0; hdr_sip = 0; hdr_dip = 0; hdr_is_v6 = 0; hdr_fix = 0;
    endtask

    // presents one packet and checks the hand-derived result one clock later
    task automatic send(string req, bit eh, logic [1:0] ei);
        cur_req = req;
        @(posedge clk); #1;
        pkt_valid = 1;
        @(posedge clk); #1;
        pkt_valid = 0;
        chk(req, res_valid === 1'b1, "res_valid", int'(res_valid), 1);
        chk(req, res_hit === eh, "res_hit", int'(res_hit), int'(eh));
        if (eh) chk(req, res_idx === ei, "res_idx", int'(res_idx), int'(ei));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        clear_hdr();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", res_valid === 0 && res_hit === 0 && res_idx === 0, "reset outputs",
            int'({res_valid, res_hit, res_idx}), 0);
        send("R1", 0, 0);

        // R2 R4 R5: rule 0, template 0, SA parts in slots 3..5, EtherType slot 9
        clr_rule();
        put_fix(2'd0, 0, 0);
        put_slot(0, 16'h0005, 16'h000F);
        put_slot(3, 16'h4455, 16'hFFFF);
        put_slot(4, 16'h2233, 16'hFFFF);
        put_slot(5, 16'h0011, 16'hFFFF);
        put_slot(9, 16'h0800, 16'hFFFF);
        commit(0, 32'h8000_0000);
        clear_hdr();
        hdr_pmask = 32'h0000_FFF5; hdr_smac = 48'h0011_2233_4455; hdr_etype = 16'h0800;
        send("R2", 1, 0);
        hdr_smac = 48'h4455_2233_0011;
        send("R5", 0, 0);
        hdr_smac = 48'h0011_2233_4455; hdr_etype = 16'h86DD;
        send("R7", 0, 0);
        hdr_etype = 16'h0800; hdr_pmask = 32'h0000_FFF6;
        send("R7", 0, 0);

        // R4: rule 1, template 1 via tid 1; DIP parts slots 2,3 and L4 source slot 5
        clr_rule();
        put_fix(2'd1, 0, 0);
        put_slot(2, 16'h0001, 16'hFFFF);
        put_slot(3, 16'h0A00, 16'hFFFF);
        put_slot(5, 16'd80, 16'hFFFF);
        commit(1, 32'h8000_0000);
        clear_hdr();
        hdr_dip = 128'h0A00_0001; hdr_l4_src = 16'd80;
        send("R4", 1, 1);
        hdr_l4_src = 16'd443; hdr_l4_dst = 16'd80;
        send("R2", 0, 0);

        // R9: both rules hit
        hdr_l4_src = 16'd80; hdr_l4_dst = 0;
        hdr_pmask = 32'h0000_FFF5; hdr_smac = 48'h0011_2233_4455; hdr_etype = 16'h0800;
        send("R9", 1, 0);

        // R8: condition flags without the valid bit, then with it
        wr_word(0, {2'd0, 4'd14}, 32'h7000_0000);
        send("R8", 1, 1);
        wr_word(0, {2'd0, 4'd14}, 32'hF000_0000);
        send("R8", 1, 0);

        // R1 R3 R5: rule 2 in odd block, tid 1 -> template 3, full IPv6 destination
        clr_rule();
        put_fix(2'd1, 0, 0);
        for (int k = 0; k < 8; k++)
            put_slot(k, 16'(128'h2001_0DB8_0000_0000_0000_0000_0000_0042 >> (16*k)), 16'hFFFF);
        put_slot(8, 16'd22, 16'hFFFF);
        commit(2, 32'h8000_0000);
        clear_hdr();
        hdr_is_v6 = 1; hdr_dip = 128'h2001_0DB8_0000_0000_0000_0000_0000_0042; hdr_l4_dst = 16'd22;
        send("R1", 1, 2);
        hdr_dip = 128'h2002_0DB8_0000_0000_0000_0000_0000_0042;
        send("R5", 0, 0);

        // R6: rule 3, tid 2 -> template 4, source with zero upper parts
        clr_rule();
        put_fix(2'd2, 0, 0);
        for (int k = 0; k < 8; k++) put_slot(k, (k == 0) ? 16'h0001 : (k == 1) ? 16'hC0A8 : 16'h0, 16'hFFFF);
        commit(3, 32'h8000_0000);
        clear_hdr();
        hdr_sip = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hC0A8_0001};
        send("R6", 1, 3);
        hdr_is_v6 = 1;
        send("R6", 0, 0);

        // R7 fixed word: source port number at hdr_fix[19:14]
        put_fix(2'd2, 22'(9) << 14, 22'h3F << 14);
        commit(3, 32'h8000_0000);
        hdr_is_v6 = 0; hdr_fix = 22'(9) << 14;
        send("R7", 1, 3);
        hdr_fix = 22'(10) << 14;
        send("R7", 0, 0);

        // R11: wildcard rule 1 with tid 3, then a selector naming template 5
        clr_rule();
        put_fix(2'd3, 0, 0);
        commit(1, 32'h8000_0000);
        clear_hdr();
        send("R11", 0, 0);
        put_fix(2'd0, 0, 0);
        commit(1, 32'h8000_0000);
        wr_word(1, 6'd0, {23'b0, 3'd2, 3'd1, 3'd5});
        send("R11", 0, 0);
        wr_word(1, 6'd0, {23'b0, 3'd2, 3'd1, 3'd0});
        send("R12", 1, 1);
        // R10: no packet, no result
        @(posedge clk); #1;
        chk("R10", res_valid === 0 && res_hit === 0, "idle result", int'({res_valid, res_hit}), 0);

        // R3 R12: tid 2, slot 9 is SIP1 under template 2 and range under template 1
        clr_rule();
        put_fix(2'd2, 0, 0);
        put_slot(9, 16'h1234, 16'hFFFF);
        commit(1, 32'h8000_0000);
        clear_hdr();
        hdr_sip = 128'h1234_0000;
        send("R3", 1, 1);
        wr_word(1, 6'd0, {23'b0, 3'd1, 3'd1, 3'd0});
        send("R12", 0, 0);
        hdr_range = 16'h1234;
        send("R3", 1, 1);

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule